// File: doc/BRIEF.md
# Line-Bundle Consumer with Generation-Tagged Redirect

This block sits at the entry of a decode stage. Fetch delivers bundles, and each bundle carries a whole line of instruction words, the PC it was fetched for and a generation tag. The block peeks at the bundle at the head of the fetch queue and selects the word that its own architectural PC points at. It hands that word on, with a valid strobe in the same cycle, and then waits for execute to return the next PC. A bundle stays in the queue while successive PCs stay inside its line. The block pulses a discard only when the next PC crosses into another line.

When the head bundle belongs to the current generation but to the wrong line, the block steps its generation. It posts a single restart request to fetch, carrying the local PC and the new generation, and throws the bundle away. Fetch is still sending bundles from the old generation at that point. These arrive with a stale tag, and the block discards them without acting on them. While the halted input is high, no bundle is consumed.

Top module: `bundle_consumer`

## Requirements
- R1: After reset the local PC equals the parameter RESET_PC and the generation is 0. No restart is pending, and with no bundle present neither word_valid_o nor bnd_discard_o is high.
- R2: A bundle whose generation differs from the local one is discarded in the cycle it is seen. It produces no word and no restart, and it leaves the local PC and generation unchanged.
- R3: A current-generation bundle is mismatched when bnd_pc_i >> log2(LINE_WORDS) differs from the local PC shifted the same way. Such a bundle is discarded in that cycle, and the local generation increments. From the next cycle rst_valid_o is high with rst_pc_o equal to the local PC and rst_gen_o equal to the new generation.
- R4: A matching bundle is accepted with word_valid_o high in the same cycle. word_o is data word k, where k is the PC's low log2(LINE_WORDS) bits and word k occupies bits [k*WORD_W +: WORD_W]. word_pc_o shows the local PC. The bundle is not discarded in that cycle.
- R5: When execute returns a next PC in the same line as the current PC, the bundle is kept (no discard), and the next word is taken from it.
- R6: When the returned next PC lies in a different line, bnd_discard_o pulses in that cycle.
- R7: While halted_i is high, a waiting bundle causes no discard, no word and no restart.
- R8: Only one restart is held at a time, and it stays stable until rst_ready_i is high. A mismatch seen while the slot is full and not being accepted stalls, with no discard and no generation change.
- R9: In a cycle where the pending restart is accepted and a new mismatch is seen, the new restart is loaded at once. rst_valid_o stays high and carries the newer generation.
- R10: The generation counts modulo 2^GEN_W.
- R11: After a word is issued, no further word is issued until execute returns the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted_i | input | 1 | Blocks bundle consumption |
| bnd_valid_i | input | 1 | A bundle is at the head of the queue |
| bnd_gen_i | input | GEN_W | Generation tag of the bundle |
| bnd_pc_i | input | PC_W | PC the bundle was fetched for |
| bnd_data_i | input | LINE_WORDS*WORD_W | Words of the line |
| nxt_valid_i | input | 1 | Execute returns the next PC |
| nxt_pc_i | input | PC_W | Next PC from execute |
| rst_ready_i | input | 1 | Fetch accepts the pending restart |
| bnd_discard_o | output | 1 | Pop the head bundle |
| word_valid_o | output | 1 | word_o is issued this cycle |
| word_o | output | WORD_W | Selected instruction word |
| word_pc_o | output | PC_W | Local architectural PC |
| rst_valid_o | output | 1 | A restart is pending |
| rst_pc_o | output | PC_W | Restart PC |
| rst_gen_o | output | GEN_W | Restart generation |

## Verification
Two functions can fall in the same cycle: fetch accepting the pending restart, and a fresh line mismatch that needs a new restart. The bench provokes this by holding rst_ready_i low until a second mismatched bundle stalls against the full slot. It then raises rst_ready_i while that bundle is still present. It also chains back-to-back redirects with rst_ready_i held high, so that the generation wraps. The judgement is that the discard appears exactly in the accepting cycle and that rst_valid_o never drops. The restart must carry the generation one beyond the previous one, modulo 2^GEN_W.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_WAIT,
        ACT_STALE,
        ACT_HOLD,
        ACT_REDIRECT,
        ACT_ISSUE
    } bc_act_e;
endpackage

// File: rtl/bc_word_select.sv
module bc_word_select #(
    parameter int WORD_W     = 12,
    parameter int LINE_WORDS = 4,
    localparam int OFS_W     = $clog2(LINE_WORDS)
) (
    input  logic [LINE_WORDS*WORD_W-1:0] line_i,
    input  logic [OFS_W-1:0]             ofs_i,
    output logic [WORD_W-1:0]            word_o
);
    logic [WORD_W-1:0] words [LINE_WORDS];

    for (genvar gi = 0; gi < LINE_WORDS; gi++) begin : g_unpack
        assign words[gi] = line_i[gi*WORD_W +: WORD_W];
    end

    always_comb begin
        word_o = words[0];
        for (int i = 0; i < LINE_WORDS; i++) begin
            if (ofs_i == OFS_W'(i)) word_o = words[i];
        end
    end
endmodule

// File: rtl/bc_restart_slot.sv
module bc_restart_slot #(
    parameter int PC_W  = 12,
    parameter int GEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [PC_W-1:0]  push_pc_i,
    input  logic [GEN_W-1:0] push_gen_i,
    input  logic             ready_i,
    output logic             free_o,
    output logic             valid_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [GEN_W-1:0] gen_o
);
    typedef struct packed {
        logic             valid;
        logic [PC_W-1:0]  pc;
        logic [GEN_W-1:0] gen;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && ready_i) slot_d.valid = 1'b0;
        if (push_i) begin
            slot_d.valid = 1'b1;
            slot_d.pc    = push_pc_i;
            slot_d.gen   = push_gen_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign free_o  = !slot_q.valid || ready_i;
    assign valid_o = slot_q.valid;
    assign pc_o    = slot_q.pc;
    assign gen_o   = slot_q.gen;

    p_held_until_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !ready_i) |=> (slot_q.valid && $stable(slot_q.pc) && $stable(slot_q.gen)));

    p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!slot_q.valid || ready_i));

    p_reload_on_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && ready_i && push_i) |=> slot_q.valid);
endmodule

// File: rtl/bc_ctrl.sv
module bc_ctrl
    import bc_pkg::*;
#(
    parameter int PC_W          = 12,
    parameter int GEN_W         = 3,
    parameter int OFS_W         = 2,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted_i,
    input  logic             bnd_valid_i,
    input  logic [GEN_W-1:0] bnd_gen_i,
    input  logic [PC_W-1:0]  bnd_pc_i,
    input  logic             nxt_valid_i,
    input  logic [PC_W-1:0]  nxt_pc_i,
    input  logic             slot_free_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [GEN_W-1:0] gen_o,
    output bc_act_e          act_o,
    output logic             discard_o,
    output logic             issue_o,
    output logic             push_o
);
    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [GEN_W-1:0] gen;
        logic             wait_nxt;
    } ctl_t;

    ctl_t st_d, st_q;
    logic same_line;

    assign same_line = (bnd_pc_i >> OFS_W) == (st_q.pc >> OFS_W);

    always_comb begin
        st_d      = st_q;
        act_o     = ACT_IDLE;
        discard_o = 1'b0;
        issue_o   = 1'b0;
        push_o    = 1'b0;
        if (st_q.wait_nxt) begin
            act_o = ACT_WAIT;
            if (nxt_valid_i) begin
                st_d.pc       = nxt_pc_i;
                st_d.wait_nxt = 1'b0;
                discard_o     = (nxt_pc_i >> OFS_W) != (st_q.pc >> OFS_W);
            end
        end else if (!halted_i && bnd_valid_i) begin
            if (bnd_gen_i != st_q.gen) begin
                act_o     = ACT_STALE;
                discard_o = 1'b1;
            end else if (!same_line) begin
                if (slot_free_i) begin
                    act_o     = ACT_REDIRECT;
                    st_d.gen  = st_q.gen + GEN_W'(1);
                    discard_o = 1'b1;
                    push_o    = 1'b1;
                end else begin
                    act_o = ACT_HOLD;
                end
            end else begin
                act_o         = ACT_ISSUE;
                issue_o       = 1'b1;
                st_d.wait_nxt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc       <= RESET_PC;
            st_q.gen      <= '0;
            st_q.wait_nxt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o  = st_q.pc;
    assign gen_o = st_q.gen;

    p_stale_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.wait_nxt && !halted_i && bnd_valid_i && bnd_gen_i != st_q.gen)
        |=> ($stable(st_q.gen) && $stable(st_q.pc)));

    p_gen_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> (st_q.gen == $past(st_q.gen) + GEN_W'(1)));

    p_halt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_i && !st_q.wait_nxt) |-> (!discard_o && !issue_o && !push_o));

    p_one_word_per_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wait_nxt |-> !issue_o);

    p_pc_moves_by_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.wait_nxt |=> (st_q.pc == $past(st_q.pc)));
endmodule

// File: rtl/bundle_consumer.sv
module bundle_consumer
    import bc_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int WORD_W     = 12,
    parameter int LINE_WORDS = 4,
    parameter int GEN_W      = 3,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         halted_i,
    input  logic                         bnd_valid_i,
    input  logic [GEN_W-1:0]             bnd_gen_i,
    input  logic [PC_W-1:0]              bnd_pc_i,
    input  logic [LINE_WORDS*WORD_W-1:0] bnd_data_i,
    input  logic                         nxt_valid_i,
    input  logic [PC_W-1:0]              nxt_pc_i,
    input  logic                         rst_ready_i,
    output logic                         bnd_discard_o,
    output logic                         word_valid_o,
    output logic [WORD_W-1:0]            word_o,
    output logic [PC_W-1:0]              word_pc_o,
    output logic                         rst_valid_o,
    output logic [PC_W-1:0]              rst_pc_o,
    output logic [GEN_W-1:0]             rst_gen_o
);
    localparam int OFS_W = $clog2(LINE_WORDS);

    logic [PC_W-1:0]  pc_q;
    logic [GEN_W-1:0] gen_q;
    logic [GEN_W-1:0] gen_next;
    bc_act_e          act;
    logic             push, issue, slot_free;

    bc_ctrl #(
        .PC_W(PC_W), .GEN_W(GEN_W), .OFS_W(OFS_W), .RESET_PC(RESET_PC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .halted_i(halted_i),
        .bnd_valid_i(bnd_valid_i), .bnd_gen_i(bnd_gen_i), .bnd_pc_i(bnd_pc_i),
        .nxt_valid_i(nxt_valid_i), .nxt_pc_i(nxt_pc_i),
        .slot_free_i(slot_free),
        .pc_o(pc_q), .gen_o(gen_q), .act_o(act),
        .discard_o(bnd_discard_o), .issue_o(issue), .push_o(push)
    );

    assign gen_next = gen_q + GEN_W'(1);

    bc_restart_slot #(.PC_W(PC_W), .GEN_W(GEN_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_pc_i(pc_q), .push_gen_i(gen_next),
        .ready_i(rst_ready_i), .free_o(slot_free),
        .valid_o(rst_valid_o), .pc_o(rst_pc_o), .gen_o(rst_gen_o)
    );

    bc_word_select #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_sel (
        .line_i(bnd_data_i), .ofs_i(pc_q[OFS_W-1:0]), .word_o(word_o)
    );

    assign word_valid_o = issue;
    assign word_pc_o    = pc_q;

    p_restart_carries_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (rst_valid_o && rst_pc_o == $past(pc_q) && rst_gen_o == gen_q));

    p_issue_not_popped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> (!bnd_discard_o && act == ACT_ISSUE));
endmodule

// File: tb/tb_bundle_consumer.sv
module tb_bundle_consumer;
    localparam int PC_W = 12, WORD_W = 12, LW = 4, GEN_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halted = 1'b0, bvalid = 1'b0, nvalid = 1'b0, rready = 1'b0;
    logic [GEN_W-1:0] bgen = '0;
    logic [PC_W-1:0] bpc = '0, npc = '0;
    logic [LW*WORD_W-1:0] bdata = '0;
    logic discard, wvalid, rvalid;
    logic [WORD_W-1:0] word;
    logic [PC_W-1:0] wpc, rpc;
    logic [GEN_W-1:0] rgen;

    int vectors = 0, miscompares = 0;
    logic [PC_W-1:0] ep = '0;
    logic [GEN_W-1:0] eg = '0;

    always #5 clk = ~clk;

    bundle_consumer dut (
        .clk(clk), .rst_n(rst_n), .halted_i(halted),
        .bnd_valid_i(bvalid), .bnd_gen_i(bgen), .bnd_pc_i(bpc), .bnd_data_i(bdata),
        .nxt_valid_i(nvalid), .nxt_pc_i(npc), .rst_ready_i(rready),
        .bnd_discard_o(discard), .word_valid_o(wvalid), .word_o(word),
        .word_pc_o(wpc), .rst_valid_o(rvalid), .rst_pc_o(rpc), .rst_gen_o(rgen)
    );

    function automatic logic [WORD_W-1:0] wval(input logic [PC_W-1:0] p, input int i);
        return WORD_W'((int'(p >> 2) * 5 + i * 3 + 1) & 12'hFFF);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic present(input logic v, input logic [GEN_W-1:0] g, input logic [PC_W-1:0] p);
        bvalid = v; bgen = g; bpc = p;
        for (int i = 0; i < LW; i++) bdata[i*WORD_W +: WORD_W] = wval(p, i);
    endtask

    task automatic issue_step(input logic [PC_W-1:0] q);
        present(1'b1, eg, ep);
        #1;
        chk("R4 valid", wvalid, 1);
        chk("R4 word", word, wval(ep, int'(ep[1:0])));
        chk("R4 pc", wpc, ep);
        chk("R4 keep", discard, 0);
        tick();
        chk("R11 no reissue", wvalid, 0);
        tick();
        nvalid = 1'b1; npc = q;
        #1;
        if ((q >> 2) == (ep >> 2)) chk("R5 kept", discard, 0);
        else chk("R6 popped", discard, 1);
        tick();
        nvalid = 1'b0;
        ep = q;
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 restart", rvalid, 0);
        chk("R1 word", wvalid, 0);
        chk("R1 discard", discard, 0);
        chk("R1 pc", wpc, 0);

        for (int k = 0; k < 48; k++) begin
            logic [PC_W-1:0] q;
            if (k % 3 != 2) q = (ep & ~12'h3) | ((ep + 12'(k % 2 + 1)) & 12'h3);
            else q = 12'((k * 37 + 5) & 12'hFFF);
            issue_step(q);
        end

        // R2 stale bundle
        present(1'b1, eg + 3'd1, ep ^ 12'h40);
        #1;
        chk("R2 discard", discard, 1);
        chk("R2 word", wvalid, 0);
        tick();
        chk("R2 no restart", rvalid, 0);
        chk("R2 pc", wpc, ep);
        issue_step(ep + 12'h4);

        // R7 halted
        halted = 1'b1;
        present(1'b1, eg, ep);
        #1;
        chk("R7 word", wvalid, 0);
        chk("R7 discard", discard, 0);
        present(1'b1, eg, ep ^ 12'h80);
        #1;
        chk("R7 discard2", discard, 0);
        tick();
        chk("R7 restart", rvalid, 0);
        halted = 1'b0;

        // R3 and R8: redirect, then hold
        rready = 1'b0;
        present(1'b1, eg, ep ^ 12'h80);
        #1;
        chk("R3 discard", discard, 1);
        chk("R3 word", wvalid, 0);
        tick();
        eg = eg + 3'd1;
        chk("R3 valid", rvalid, 1);
        chk("R3 pc", rpc, ep);
        chk("R3 gen", rgen, eg);
        present(1'b1, eg, ep ^ 12'h100);
        for (int c = 0; c < 3; c++) begin
            #1;
            chk("R8 stall", discard, 0);
            tick();
            chk("R8 held", rvalid, 1);
            chk("R8 gen", rgen, eg);
        end
        // R9 accept and reload in one cycle
        rready = 1'b1;
        #1;
        chk("R9 discard", discard, 1);
        tick();
        eg = eg + 3'd1;
        chk("R9 valid", rvalid, 1);
        chk("R9 gen", rgen, eg);

        // R10 wrap via chained redirects
        for (int n = 0; n < 10; n++) begin
            present(1'b1, eg, ep ^ 12'h200);
            #1;
            chk("R10 discard", discard, 1);
            tick();
            eg = eg + 3'd1;
            chk("R10 valid", rvalid, 1);
            chk("R10 gen", rgen, eg);
        end
        present(1'b0, eg, ep);
        tick();
        chk("R8 drained", rvalid, 0);
        issue_step(ep + 12'h1);
        chk("R10 pc", wpc, ep);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule